// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a memory-mapped watchdog. Software loads a 20-bit down-counter, selects a reset mode in a 2-bit configuration field of the control register, and then keeps reloading the counter. While the watchdog runs, the counter drops by one on every tick-enable pulse. If the counter reaches zero while the watchdog is still running, the block drives a fixed-length reset pulse toward the chip's reset network. It also records the cause in a status register and disarms itself.

Every write must carry the key byte 0x5A in bits 31:24. A write with any other key leaves all state untouched. The status register also holds boot-partition bits that software writes before it requests a reset. A watchdog-generated reset does not clear these bits. Only the power-on reset input clears them. When the even bits 0 through 10 are all set, the block raises a halt indication.

Top module: `wdg_reset_ctrl`

## Requirements
- R1: After power-on reset, all three registers read 0, and both `chip_rst_o` and `halt_o` are low.
- R2: A write whose bits 31:24 differ from 0x5A leaves the control, status and count registers unchanged.
- R3: Reads always return 0 in bits 31:24. Offset 0x1C returns the control field in bits 23:0. Offset 0x20 returns the status field in bits 23:0. Offset 0x24 returns the remaining count in bits 19:0.
- R4: The watchdog runs while control bit 5 is set. While it runs and the count is non-zero, the count drops by exactly one per cycle with `tick_en` high. While it is not running, the count holds.
- R5: If the count is 0 while the watchdog runs, `chip_rst_o` goes high at the next clock edge and stays high for exactly PULSE_LEN cycles.
- R6: On expiry, control bits 5:4 become 2'b00 and the other control bits are kept. Status bit 5 is set when bits 5:4 were 2'b10 (full reset). Status bit 6 is set when they were 2'b11 (hard reset).
- R7: A keyed write of 0x102 to the control register leaves bits 5:4 at 2'b00. This stops the countdown, and no reset pulse follows.
- R8: Status bits written by software survive a watchdog expiry. Only `por_rst` clears them.
- R9: `halt_o` is high exactly when status bits 0, 2, 4, 6, 8 and 10 are all set, for example after writing 0x555.
- R10: A read-modify-write arm works and keeps the rest of the field. Software reads the control register, clears bits 5:4, ORs in 0x20 and writes the result with the key. Every other bit is then preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| tick_en | input | 1 | Countdown tick enable |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, key in bits 31:24 |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| chip_rst_o | output | 1 | Reset pulse toward the chip |
| halt_o | output | 1 | Halt pattern present in status |

## Verification
Register writes take effect at the edge on which `bus_wr` is sampled. Read data follows the address combinationally, so the bench reads one time step after it sets the address on a falling edge. The counter loses one count at each rising edge with `tick_en` high. A count of N therefore reaches zero N edges after ticking starts. The reset pulse begins one edge after that and lasts PULSE_LEN cycles, so the first high sample is due at falling edge N+1. The bench counts falling edges from the moment it raises `tick_en` and checks the exact first cycle and the width of the pulse against those numbers.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int FIELD_W = 24;
    localparam int CNT_W   = 20;

    localparam logic [7:0] WR_KEY = 8'h5A;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h24;

    localparam int CFG_LSB        = 4;
    localparam int RUN_BIT        = 5;
    localparam int CAUSE_FULL_BIT = 5;
    localparam int CAUSE_HARD_BIT = 6;

    typedef enum logic [1:0] {
        CFG_OFF   = 2'b00,
        CFG_SPARE = 2'b01,
        CFG_FULL  = 2'b10,
        CFG_HARD  = 2'b11
    } cfg_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic key_ok(input logic [DATA_W-1:0] d);
        return d[DATA_W-1 -: 8] == WR_KEY;
    endfunction

    function automatic logic halt_pattern(input logic [FIELD_W-1:0] s);
        return s[0] & s[2] & s[4] & s[6] & s[8] & s[10];
    endfunction

endpackage

// File: rtl/wdg_regif.sv
module wdg_regif
    import wdg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic               expire,
    input  logic [CNT_W-1:0]   cnt_val,
    output logic [FIELD_W-1:0] ctrl_q,
    output logic [FIELD_W-1:0] stat_q,
    output logic               load_en,
    output logic [CNT_W-1:0]   load_val,
    output logic [DATA_W-1:0]  rdata
);

    logic wr_ok;
    logic wr_ctrl;
    logic wr_stat;
    cfg_e cfg_now;

    assign wr_ok    = req.wr && key_ok(req.data);
    assign wr_ctrl  = wr_ok && (req.addr == OFS_CTRL);
    assign wr_stat  = wr_ok && (req.addr == OFS_STAT);
    assign load_en  = wr_ok && (req.addr == OFS_COUNT);
    assign load_val = req.data[CNT_W-1:0];
    assign cfg_now  = cfg_e'(ctrl_q[CFG_LSB +: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= req.data[FIELD_W-1:0];
            end
            if (wr_stat) begin
                stat_q <= req.data[FIELD_W-1:0];
            end
            if (expire) begin
                ctrl_q[CFG_LSB +: 2] <= CFG_OFF;
                if (cfg_now == CFG_HARD) begin
                    stat_q[CAUSE_HARD_BIT] <= 1'b1;
                end else begin
                    stat_q[CAUSE_FULL_BIT] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (req.addr)
            OFS_CTRL:  rdata[FIELD_W-1:0] = ctrl_q;
            OFS_STAT:  rdata[FIELD_W-1:0] = stat_q;
            OFS_COUNT: rdata[CNT_W-1:0]   = cnt_val;
            default:   rdata = '0;
        endcase
    end

    AST_KEYLESS_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (req.wr && !key_ok(req.data) && !expire) |=> ($stable(ctrl_q) && $stable(stat_q))); // R2

    AST_EXPIRE_DISARMS: assert property (@(posedge clk) disable iff (rst)
        expire |=> !ctrl_q[RUN_BIT]); // R6

    AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (expire && cfg_now == CFG_FULL) |=> stat_q[CAUSE_FULL_BIT]); // R6

    AST_HARD_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (expire && cfg_now == CFG_HARD) |=> stat_q[CAUSE_HARD_BIT]); // R6

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         running,
    input  logic         tick_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic         expire
);

    logic at_zero;

    assign at_zero = (cnt_q == '0);
    assign expire  = running && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (running && tick_en && !at_zero) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (running && tick_en && !at_zero && !load_en) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!running && !load_en) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse_o
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= PW'(PULSE_LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse_o = (left_q != '0);

    AST_PULSE_ON_EXPIRE: assert property (@(posedge clk) disable iff (rst)
        fire |=> pulse_o); // R5

    AST_PULSE_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        (!pulse_o && !fire) |=> !pulse_o); // R5

endmodule

// File: rtl/wdg_reset_ctrl.sv
module wdg_reset_ctrl
    import wdg_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic        clk,
    input  logic        por_rst,
    input  logic        tick_en,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        chip_rst_o,
    output logic        halt_o
);

    bus_req_t           req;
    logic [FIELD_W-1:0] ctrl_q;
    logic [FIELD_W-1:0] stat_q;
    logic               load_en;
    logic [CNT_W-1:0]   load_val;
    logic [CNT_W-1:0]   cnt_q;
    logic               expire;

    assign req = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    wdg_regif u_regif (
        .clk      (clk),
        .rst      (por_rst),
        .req      (req),
        .expire   (expire),
        .cnt_val  (cnt_q),
        .ctrl_q   (ctrl_q),
        .stat_q   (stat_q),
        .load_en  (load_en),
        .load_val (load_val),
        .rdata    (bus_rdata)
    );

    wdg_counter #(.W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (por_rst),
        .running  (ctrl_q[RUN_BIT]),
        .tick_en  (tick_en),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt_q    (cnt_q),
        .expire   (expire)
    );

    wdg_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst     (por_rst),
        .fire    (expire),
        .pulse_o (chip_rst_o)
    );

    assign halt_o = halt_pattern(stat_q);

endmodule

// File: tb/tb_wdg_reset_ctrl.sv
`timescale 1ns/100ps
module tb_wdg_reset_ctrl;

    localparam int PLEN = 4;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        chip_rst_o;
    logic        halt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    wdg_reset_ctrl #(.PULSE_LEN(PLEN)) dut (
        .clk(clk), .por_rst(por_rst), .tick_en(tick_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .chip_rst_o(chip_rst_o), .halt_o(halt_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_por();
        @(negedge clk);
        por_rst = 1'b1;
        tick_en = 1'b0;
        repeat (2) @(negedge clk);
        por_rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_por();
        rd(8'h1C, v); check("R1 ctrl", v, 32'h0);
        rd(8'h20, v); check("R1 status", v, 32'h0);
        rd(8'h24, v); check("R1 count", v, 32'h0);
        check("R1 outputs", {30'h0, chip_rst_o, halt_o}, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(8'h24, 32'h5AFFFFFF);
        rd(8'h24, v); check("R3 count field", v, 32'h000FFFFF);
        wr(8'h20, 32'h5A123402);
        rd(8'h20, v); check("R3 status field", v, 32'h00123402);
        wr(8'h1C, 32'h5AABC00C);
        rd(8'h1C, v); check("R3 ctrl field key zero", v, 32'h00ABC00C);
    endtask

    task automatic t_bad_key();
        logic [31:0] v;
        wr(8'h1C, 32'hA5000020);
        wr(8'h20, 32'h00000555);
        wr(8'h24, 32'h5B000009);
        rd(8'h1C, v); check("R2 ctrl kept", v, 32'h00ABC00C);
        rd(8'h20, v); check("R2 status kept", v, 32'h00123402);
        rd(8'h24, v); check("R2 count kept", v, 32'h000FFFFF);
        check("R2 no reset pulse", {31'h0, chip_rst_o}, 32'h0);
    endtask

    task automatic t_hold_and_step();
        logic [31:0] v;
        wr(8'h1C, 32'h5A000000);
        wr(8'h24, 32'h5A000007);
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        rd(8'h24, v); check("R4 hold while stopped", v, 32'h7);
        wr(8'h24, 32'h5A000064);
        wr(8'h1C, 32'h5A000020);
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        rd(8'h24, v); check("R4 three ticks", v, 32'd97);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int hi = 0;
        wr(8'h1C, 32'h5A000102);
        rd(8'h1C, v); check("R7 ctrl after stop", v, 32'h102);
        tick_en = 1'b1;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (chip_rst_o) hi++;
        end
        tick_en = 1'b0;
        rd(8'h24, v); check("R7 count frozen", v, 32'd97);
        check("R7 no pulse", hi, 0);
    endtask

    task automatic t_full_expiry();
        logic [31:0] v;
        int first = -1;
        int hi = 0;
        wr(8'h20, 32'h5A000100);
        wr(8'h24, 32'h5A000003);
        wr(8'h1C, 32'h5A000020);
        tick_en = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (chip_rst_o) begin
                hi++;
                if (first < 0) first = i;
            end
        end
        tick_en = 1'b0;
        check("R5 pulse start cycle", first, 4);
        check("R5 pulse width", hi, PLEN);
        rd(8'h1C, v); check("R6 ctrl disarmed", v, 32'h0);
        rd(8'h20, v); check("R6 R8 full cause and kept bits", v, 32'h120);
    endtask

    task automatic t_hard_and_rmw();
        logic [31:0] v;
        logic [31:0] nv;
        wr(8'h20, 32'h5A000401);
        wr(8'h24, 32'h5A000002);
        wr(8'h1C, 32'h5A000130);
        tick_en = 1'b1;
        repeat (12) @(negedge clk);
        tick_en = 1'b0;
        rd(8'h20, v); check("R6 R8 hard cause keeps bits", v, 32'h441);
        rd(8'h1C, v); check("R6 other ctrl bits kept", v, 32'h100);
        wr(8'h24, 32'h5A000800);
        wr(8'h1C, 32'h5A000A1C);
        rd(8'h1C, v);
        nv = (v & 32'hFFFFFFCF) | 32'h20 | 32'h5A000000;
        wr(8'h1C, nv);
        rd(8'h1C, v); check("R10 rmw arm", v, 32'hA2C);
        tick_en = 1'b1;
        repeat (4) @(negedge clk);
        tick_en = 1'b0;
        rd(8'h24, v); check("R10 armed counts", v, 32'h7FC);
        wr(8'h1C, 32'h5A000102);
    endtask

    task automatic t_halt_and_por();
        logic [31:0] v;
        wr(8'h20, 32'h5A000555);
        @(negedge clk); check("R9 halt set", {31'h0, halt_o}, 32'h1);
        wr(8'h20, 32'h5A000554);
        @(negedge clk); check("R9 halt clear", {31'h0, halt_o}, 32'h0);
        wr(8'h20, 32'h5A000555);
        do_por();
        rd(8'h20, v); check("R8 por clears status", v, 32'h0);
        check("R8 halt after por", {31'h0, halt_o}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_readback();
        t_bad_key();
        t_hold_and_step();
        t_stop();
        t_full_expiry();
        t_hard_and_rmw();
        t_halt_and_por();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule